// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns four power-mode bits held in a CPU status word into clock enables. The enables go to the main CPU clock, the subsystem clock and the auxiliary clock, to the digitally controlled oscillator (DCO), and to the DC generator that biases the DCO. The CPU writes the bits through a write strobe. Each combination of bits selects one of six power modes: active, or low-power levels 0 to 4. The bits are independent of one another, so the enable decode is done per bit and not from a mode table.

The block also handles wake-up. When any enabled interrupt line is pending and no interrupt is in service, the block does four things:
- it saves the current bits;
- it clears the CPU-off, oscillator-off and clock-gate-1 bits, so the CPU runs;
- it leaves clock-gate-0 untouched;
- it marks an interrupt as in service.

A return strobe either restores the saved copy or, when the CPU asks for it, loads bits the CPU supplies. Loading supplied bits is how an interrupt handler makes the system wake into a different mode. Peripherals that need the DC generator are merged outside into a single request input.

Bit positions in every 4-bit mode word: bit 3 CPU-off, bit 2 oscillator-off, bit 1 clock-gate-1, bit 0 clock-gate-0.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: After synchronous reset, mode_bits is 0 and saved_bits is 0. in_service is low, every clock enable is high and cpu_halt is low.
- R2: mclk_en is low exactly when bit 3 (CPU-off) of mode_bits is set, and cpu_halt is its inverse.
- R3: smclk_en is low exactly when bit 1 (clock-gate-1) is set. aclk_en is low exactly when bit 2 (oscillator-off) is set.
- R4: dco_en is high when bit 3 is clear or bit 1 is clear, and low otherwise.
- R5: dcgen_en is high when bit 3 is clear, or bit 0 (clock-gate-0) is clear, or dcgen_req is high. It is low otherwise.
- R6: A status write (sr_wr high) with no wake-up changes mode_bits to sr_wdata at the next clock edge. All enables follow at that same edge.
- R7: A wake-up is any bit set in irq_pend & irq_en. A wake-up while not in service sets in_service, loads the current bits into saved_bits, and leaves mode_bits with bits 3..1 cleared and bit 0 unchanged. A pending line whose enable is low has no effect.
- R8: A wake-up in the same cycle as a status write saves the written value, and the CPU clock is running after that edge.
- R9: rti high while in service, with rti_modify low and no wake-up, copies saved_bits into mode_bits and clears in_service.
- R10: rti with rti_modify high loads rti_wdata into mode_bits instead of the saved copy.
- R11: rti while not in service has no effect on mode_bits, saved_bits or in_service.
- R12: A wake-up in the same cycle as rti while in service saves the bits being restored, keeps in_service high, and applies the wake-up clearing of R7.
- R13: A wake-up while in service without rti leaves saved_bits unchanged and clears bits 3..1 of the resulting mode_bits. That result is the written value when sr_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_wr | input | 1 | Status-word write strobe |
| sr_wdata | input | 4 | Mode bits to write |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| rti | input | 1 | Return-from-interrupt strobe |
| rti_modify | input | 1 | Load rti_wdata instead of the saved copy on return |
| rti_wdata | input | 4 | Modified mode bits for return |
| dcgen_req | input | 1 | Peripheral request to keep the DC generator on |
| mode_bits | output | 4 | Current mode bits |
| saved_bits | output | 4 | Copy saved at interrupt entry |
| in_service | output | 1 | Interrupt in service |
| cpu_halt | output | 1 | CPU halted |
| mclk_en | output | 1 | Main CPU clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dco_en | output | 1 | DCO enable |
| dcgen_en | output | 1 | DC generator enable |

## Verification
Every result of this block appears one clock edge after its stimulus: mode, saved copy, service flag and all five enables. That includes the effect of dcgen_req, because the enables are registered. The bench applies inputs on the falling edge and lets exactly one rising edge pass. It then compares every output on the next falling edge against a model built from the requirements. For the decode requirements, the bench sweeps all sixteen bit combinations with the peripheral request both low and high. Wake-up, return and collision cases follow from known starting states.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // bit 3 CPU-off, bit 2 oscillator-off, bit 1 clock-gate-1, bit 0 clock-gate-0
  typedef struct packed {
    logic cpu_off;
    logic osc_off;
    logic gate1;
    logic gate0;
  } lpm_bits_t;

  typedef struct packed {
    logic mclk;
    logic smclk;
    logic aclk;
    logic dco;
    logic dcgen;
  } clk_en_t;

  localparam lpm_bits_t LPM_ACTIVE = '{cpu_off: 1'b0, osc_off: 1'b0, gate1: 1'b0, gate0: 1'b0};

  // Interrupt entry clears three bits; clock-gate-0 survives.
  function automatic lpm_bits_t lpm_wake_clear(input lpm_bits_t b);
    lpm_bits_t r;
    r = LPM_ACTIVE;
    r.gate0 = b.gate0;
    return r;
  endfunction

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               wake
);
  logic [NUM_IRQ-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
      assign gated[gi] = irq_pend[gi] & irq_en[gi];
    end
  endgenerate

  assign wake = |gated;
endmodule

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sr_wr,
  input  lpm_bits_t sr_wdata,
  input  logic      wake,
  input  logic      rti,
  input  logic      rti_modify,
  input  lpm_bits_t rti_wdata,
  output lpm_bits_t mode_d,
  output lpm_bits_t mode_q,
  output lpm_bits_t saved_q,
  output logic      in_isr_q
);
  lpm_bits_t base;
  lpm_bits_t saved_d;
  logic      in_isr_d;
  logic      ret_ok;
  logic      entering;

  assign ret_ok   = in_isr_q & rti;
  assign entering = wake & (~in_isr_q | rti);

  always_comb begin
    base = mode_q;
    if (ret_ok) begin
      base = rti_modify ? rti_wdata : saved_q;
    end else if (sr_wr) begin
      base = sr_wdata;
    end

    mode_d  = wake ? lpm_wake_clear(base) : base;
    saved_d = entering ? base : saved_q;

    if (wake) begin
      in_isr_d = 1'b1;
    end else if (ret_ok) begin
      in_isr_d = 1'b0;
    end else begin
      in_isr_d = in_isr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= LPM_ACTIVE;
      saved_q  <= LPM_ACTIVE;
      in_isr_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      saved_q  <= saved_d;
      in_isr_q <= in_isr_d;
    end
  end
endmodule

// File: rtl/lpm_enable_map.sv
module lpm_enable_map
  import lpm_pkg::*;
(
  input  lpm_bits_t bits,
  input  logic      dcgen_req,
  output clk_en_t   en
);
  always_comb begin
    en.mclk  = ~bits.cpu_off;
    en.smclk = ~bits.gate1;
    en.aclk  = ~bits.osc_off;
    en.dco   = ~bits.cpu_off | ~bits.gate1;
    en.dcgen = ~bits.cpu_off | ~bits.gate0 | dcgen_req;
  end
endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int MW = $bits(lpm_bits_t)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sr_wr,
  input  logic [MW-1:0]      sr_wdata,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               rti,
  input  logic               rti_modify,
  input  logic [MW-1:0]      rti_wdata,
  input  logic               dcgen_req,
  output logic [MW-1:0]      mode_bits,
  output logic [MW-1:0]      saved_bits,
  output logic               in_service,
  output logic               cpu_halt,
  output logic               mclk_en,
  output logic               smclk_en,
  output logic               aclk_en,
  output logic               dco_en,
  output logic               dcgen_en
);
  logic      wake;
  lpm_bits_t mode_d, mode_q, saved_q;
  logic      in_isr_q;
  clk_en_t   en_d;
  clk_en_t   en_q;
  logic      halt_q;

  lpm_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .wake     (wake)
  );

  lpm_mode_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .sr_wr      (sr_wr),
    .sr_wdata   (lpm_bits_t'(sr_wdata)),
    .wake       (wake),
    .rti        (rti),
    .rti_modify (rti_modify),
    .rti_wdata  (lpm_bits_t'(rti_wdata)),
    .mode_d     (mode_d),
    .mode_q     (mode_q),
    .saved_q    (saved_q),
    .in_isr_q   (in_isr_q)
  );

  lpm_enable_map u_map (
    .bits      (mode_d),
    .dcgen_req (dcgen_req),
    .en        (en_d)
  );

  // Enables are registered alongside the mode so both change at one edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '1;
      halt_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      halt_q <= mode_d.cpu_off;
    end
  end

  assign mode_bits  = mode_q;
  assign saved_bits = saved_q;
  assign in_service = in_isr_q;
  assign cpu_halt   = halt_q;
  assign mclk_en    = en_q.mclk;
  assign smclk_en   = en_q.smclk;
  assign aclk_en    = en_q.aclk;
  assign dco_en     = en_q.dco;
  assign dcgen_en   = en_q.dcgen;
endmodule

// File: rtl/lpm_clkgate_ctrl_chk.sv
module lpm_clkgate_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               sr_wr,
  input logic [3:0]         sr_wdata,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               rti,
  input logic               rti_modify,
  input logic [3:0]         rti_wdata,
  input logic [3:0]         mode_bits,
  input logic [3:0]         saved_bits,
  input logic               in_service,
  input logic               cpu_halt,
  input logic               mclk_en,
  input logic               dcgen_req
);
  logic wk;
  assign wk = |(irq_pend & irq_en);

  // R2 / R8: a wake-up never leaves the CPU clock gated
  a_r8_wake_runs_cpu: assert property (@(posedge clk) disable iff (rst)
    wk |=> (mclk_en && !cpu_halt && in_service));

  // R7: clock-gate-0 survives interrupt entry
  a_r7_gate0_kept: assert property (@(posedge clk) disable iff (rst)
    (wk && !in_service && !sr_wr) |=> (mode_bits[0] == $past(mode_bits[0]) && saved_bits == $past(mode_bits)));

  // R9: plain return restores the saved copy
  a_r9_restore: assert property (@(posedge clk) disable iff (rst)
    (in_service && rti && !rti_modify && !wk) |=> (mode_bits == $past(saved_bits) && !in_service));

  // R10: modified return loads supplied bits
  a_r10_modified: assert property (@(posedge clk) disable iff (rst)
    (in_service && rti && rti_modify && !wk) |=> (mode_bits == $past(rti_wdata)));

  // R6: write takes effect at the next edge
  a_r6_write: assert property (@(posedge clk) disable iff (rst)
    (sr_wr && !wk && !(in_service && rti)) |=> (mode_bits == $past(sr_wdata)));

  // R11: stray return is ignored
  a_r11_stray_rti: assert property (@(posedge clk) disable iff (rst)
    (!in_service && rti && !wk && !sr_wr) |=> ($stable(mode_bits) && $stable(saved_bits) && !in_service));
endmodule

bind lpm_clkgate_ctrl lpm_clkgate_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sr_wr      (sr_wr),
  .sr_wdata   (sr_wdata),
  .irq_pend   (irq_pend),
  .irq_en     (irq_en),
  .rti        (rti),
  .rti_modify (rti_modify),
  .rti_wdata  (rti_wdata),
  .mode_bits  (mode_bits),
  .saved_bits (saved_bits),
  .in_service (in_service),
  .cpu_halt   (cpu_halt),
  .mclk_en    (mclk_en),
  .dcgen_req  (dcgen_req)
);

// File: tb/lpm_clkgate_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_clkgate_ctrl_bench;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst;
  logic sr_wr, rti, rti_modify, dcgen_req;
  logic [3:0] sr_wdata, rti_wdata;
  logic [NI-1:0] irq_pend, irq_en;
  logic [3:0] mode_bits, saved_bits;
  logic in_service, cpu_halt, mclk_en, smclk_en, aclk_en, dco_en, dcgen_en;

  int vectors = 0;
  int miscompares = 0;

  logic [3:0] m_mode, m_saved;
  logic       m_isr;

  always #2.5 clk = ~clk;

  lpm_clkgate_ctrl #(.NUM_IRQ(NI)) u_lpm_clkgate_ctrl (
    .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .irq_pend(irq_pend), .irq_en(irq_en), .rti(rti), .rti_modify(rti_modify),
    .rti_wdata(rti_wdata), .dcgen_req(dcgen_req), .mode_bits(mode_bits),
    .saved_bits(saved_bits), .in_service(in_service), .cpu_halt(cpu_halt),
    .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
    .dco_en(dco_en), .dcgen_en(dcgen_en)
  );

  // {mclk, smclk, aclk, dco, dcgen} from R2..R5
  function automatic logic [4:0] exp_en(input logic [3:0] b, input logic rq);
    return {~b[3], ~b[1], ~b[2], ~b[3] | ~b[1], ~b[3] | ~b[0] | rq};
  endfunction

  task automatic check(input string req);
    logic [14:0] act, exp;
    act = {mode_bits, saved_bits, in_service, cpu_halt, mclk_en, smclk_en, aclk_en, dco_en, dcgen_en};
    exp = {m_mode, m_saved, m_isr, m_mode[3], exp_en(m_mode, dcgen_req)};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called on a falling edge; drives, lets one rising edge pass, checks.
  task automatic step(input logic w, input logic [3:0] wd, input logic [NI-1:0] pend,
                      input logic [NI-1:0] en, input logic rt, input logic rm,
                      input logic [3:0] rd, input logic rq, input string req);
    logic wake;
    logic [3:0] base;
    sr_wr = w; sr_wdata = wd; irq_pend = pend; irq_en = en;
    rti = rt; rti_modify = rm; rti_wdata = rd; dcgen_req = rq;
    wake = |(pend & en);
    base = m_mode;
    if (m_isr && rt) base = rm ? rd : m_saved;
    else if (w) base = wd;
    if (wake && (!m_isr || rt)) m_saved = base;
    if (wake) m_isr = 1'b1;
    else if (m_isr && rt) m_isr = 1'b0;
    m_mode = wake ? {3'b000, base[0]} : base;
    @(posedge clk);
    @(negedge clk);
    check(req);
    sr_wr = 1'b0; rti = 1'b0; irq_pend = '0;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; sr_wr = 0; sr_wdata = 0; irq_pend = 0; irq_en = 0;
    rti = 0; rti_modify = 0; rti_wdata = 0; dcgen_req = 0;
    m_mode = 0; m_saved = 0; m_isr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1");

    // R2 R3 R4 R5 R6: full sweep of the mode word with request low and high
    for (int rq = 0; rq < 2; rq++)
      for (int v = 0; v < 16; v++)
        step(1'b1, 4'(v), '0, '0, 1'b0, 1'b0, 4'h0, 1'(rq), "R2/R3/R4/R5/R6");

    // R7: masked pending ignored, then enabled wake from deepest mode
    step(1'b1, 4'hF, '0, '0, 0, 0, 4'h0, 0, "R6");
    step(1'b0, 4'h0, 4'b0100, 4'b1011, 0, 0, 4'h0, 0, "R7");
    step(1'b0, 4'h0, 4'b0100, 4'b0100, 0, 0, 4'h0, 0, "R7");
    // R9: plain return back to deepest mode
    step(1'b0, 4'h0, '0, 4'b0100, 1, 0, 4'h0, 0, "R9");
    // R11: stray return ignored
    step(1'b0, 4'h0, '0, 4'b0100, 1, 0, 4'h3, 0, "R11");

    // R8: write into a low-power mode collides with a wake-up
    step(1'b1, 4'h0, '0, '0, 0, 0, 4'h0, 0, "R6");
    step(1'b1, 4'hA, 4'b0001, 4'b0001, 0, 0, 4'h0, 0, "R8");
    // R13: wake while in service with a write
    step(1'b1, 4'hE, 4'b0010, 4'b0010, 0, 0, 4'h0, 0, "R13");
    // R10: modified return
    step(1'b0, 4'h0, '0, '0, 1, 1, 4'h8, 1, "R10");
    // R12: wake with return
    step(1'b0, 4'h0, 4'b0001, 4'b0001, 0, 0, 4'h0, 0, "R7");
    step(1'b0, 4'h0, 4'b1000, 4'b1000, 1, 1, 4'h9, 0, "R12");
    step(1'b0, 4'h0, '0, '0, 1, 0, 4'h0, 0, "R9");

    // R7: gate0 kept through entry from LPM1-like mode
    step(1'b1, 4'h9, '0, '0, 0, 0, 4'h0, 0, "R6");
    step(1'b0, 4'h0, 4'b1111, 4'b1111, 0, 0, 4'h0, 0, "R7");
    step(1'b0, 4'h0, '0, '0, 1, 0, 4'h0, 1, "R9");

    // R1: reset again from a deep mode
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_saved = 0; m_isr = 0;
    check("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule